// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Error Flags

This block turns an asynchronous serial line into bytes. The line is idle high. Each character begins with a low start bit, followed by 7 or 8 data bits sent least significant bit first. An even or odd parity bit may follow. The character ends with one or two high stop bits. The receive clock runs at 1, 16 or 64 times the bit rate, chosen by a 2-bit divider code. A fourth code holds the receiver in a master-reset state.

Each finished character goes into a single holding register, which is presented as a valid/ready stream:
- `out_valid` is the data-full flag.
- A cycle with `out_valid` and `out_ready` both high is the host's read. It empties the register.
- While `out_valid` is high and `out_ready` is low, the host applies back-pressure: the held character and its flags stay frozen.
- A character that completes under back-pressure is discarded, and the overrun flag is raised.
- A completion in the same cycle as a read is accepted normally.

The framing and parity flags describe the held character. The overrun flag stays set until the next read.

Top module: `async_rx`

## Requirements
- R1: `div_sel` selects the bit period: 2'b00 is 1 clock per bit, 2'b01 is 16 clocks, and 2'b10 is 64 clocks. 2'b11 forces the receiver idle and, on the following clock, clears `out_valid` and all error flags.
- R2: Data bits arrive least significant bit first. With `len8`=1 all 8 bits are kept. With `len8`=0, 7 bits are kept and `out_data[7]` reads 0.
- R3: `out_valid` rises once a complete character has been received. It falls after a cycle with `out_valid` and `out_ready` both high, unless a new character completes in that same cycle. Reset clears it.
- R4: While `out_valid`=1 and `out_ready`=0, `out_data` and the error flags do not change.
- R5: `err_frame` is 1 for a character whose first stop bit was sampled low.
- R6: With `parity_en`=1, `err_parity` is 1 when the data bits and the parity bit together hold an odd number of ones (`parity_odd`=0) or an even number of ones (`parity_odd`=1). With `parity_en`=0 no parity bit is expected, and `err_parity` stays 0.
- R7: When a character completes while `out_valid`=1 and no read occurs, `err_overrun` becomes 1, the held character is kept, and the new one is dropped. The next read clears `err_overrun`.
- R8: A start is a high-to-low change on the synchronized line. At 16 or 64 clocks per bit, the start is confirmed at half a bit period. A low that has ended by then is ignored, and the receiver returns to idle.
- R9: With `two_stop`=1, the second stop bit is timed but not checked. A low second stop bit causes no framing error and does not start a new character.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive clock, 1/16/64 times the bit rate |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_line | input | 1 | Asynchronous serial input, idle high |
| div_sel | input | 2 | Clocks-per-bit code; 2'b11 is master reset |
| len8 | input | 1 | 1: 8 data bits, 0: 7 data bits |
| parity_en | input | 1 | A parity bit follows the data |
| parity_odd | input | 1 | 1: odd parity, 0: even parity |
| two_stop | input | 1 | Two stop bits instead of one |
| out_ready | input | 1 | Host read strobe (stream ready) |
| out_valid | output | 1 | Data-full flag (stream valid) |
| out_data | output | 8 | Held character |
| err_frame | output | 1 | Held character had a low first stop bit |
| err_parity | output | 1 | Held character failed parity |
| err_overrun | output | 1 | A character was lost while the register was full |

## Verification
Several internal faults each show up at the ports, and they show up within one character:
- A bit counter or sample point that is off by one clock sends a shifted or swapped byte to `out_data`. This is visible as soon as `out_valid` rises.
- A wrong start-confirmation point lets a short glitch raise `out_valid` about one character time later.
- Faulty holding-register control either fails to set `err_overrun` when a second character lands under back-pressure, or overwrites the held byte. Either is visible one cycle after that character completes.
- A parity or stop-bit slip flips `err_parity` or `err_frame` on the same cycle the character is presented.

// File: rtl/async_rx_pkg.sv
package async_rx_pkg;
  localparam logic [1:0] DIV_X1   = 2'b00;
  localparam logic [1:0] DIV_X16  = 2'b01;
  localparam logic [1:0] DIV_X64  = 2'b10;
  localparam logic [1:0] DIV_MRST = 2'b11;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP,
    ST_STOP2
  } rx_state_t;
endpackage

// File: rtl/async_rx_sync.sv
module async_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;

  genvar gi;
  generate
    for (gi = 0; gi < STAGES; gi++) begin : g_stage
      if (gi == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!rst_n) chain[gi] <= 1'b1;
          else        chain[gi] <= din;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (!rst_n) chain[gi] <= 1'b1;
          else        chain[gi] <= chain[gi-1];
        end
      end
    end
  endgenerate

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/async_rx_frame.sv
module async_rx_frame
  import async_rx_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int DIV_MID = 16,
  parameter int DIV_HI  = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              s,
  input  logic [1:0]        div_sel,
  input  logic              len8,
  input  logic              parity_en,
  input  logic              parity_odd,
  input  logic              two_stop,
  output logic              done,
  output logic [DATA_W-1:0] dout,
  output logic              fe,
  output logic              pe
);
  localparam int CNT_W = $clog2(DIV_HI) + 1;
  localparam int IDX_W = $clog2(DATA_W) + 1;

  rx_state_t         state;
  logic [CNT_W-1:0]  cnt;
  logic [CNT_W-1:0]  period;
  logic [CNT_W-1:0]  half;
  logic [IDX_W-1:0]  bit_idx;
  logic [IDX_W-1:0]  last_idx;
  logic [DATA_W-1:0] sh;
  logic [DATA_W-1:0] word;
  logic              s_prev;
  logic              par_bit;
  logic              tick;
  logic              mrst;

  always_comb begin
    case (div_sel)
      DIV_X16: period = CNT_W'(DIV_MID);
      DIV_X64: period = CNT_W'(DIV_HI);
      default: period = CNT_W'(1);
    endcase
  end

  assign half     = period >> 1;
  assign tick     = (cnt == period - CNT_W'(1));
  assign mrst     = (div_sel == DIV_MRST);
  assign last_idx = len8 ? IDX_W'(DATA_W - 1) : IDX_W'(DATA_W - 2);
  assign word     = len8 ? sh : (sh >> 1);

  always_ff @(posedge clk) begin
    if (!rst_n || mrst) begin
      state   <= ST_IDLE;
      cnt     <= '0;
      bit_idx <= '0;
      sh      <= '0;
      s_prev  <= 1'b1;
      par_bit <= 1'b0;
      done    <= 1'b0;
      dout    <= '0;
      fe      <= 1'b0;
      pe      <= 1'b0;
    end else begin
      s_prev <= s;
      done   <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          cnt     <= '0;
          bit_idx <= '0;
          if (s_prev && !s) begin
            if (div_sel == DIV_X1) state <= ST_DATA;
            else                   state <= ST_START;
          end
        end
        ST_START: begin
          if (cnt == half - CNT_W'(1)) begin
            cnt   <= '0;
            state <= s ? ST_IDLE : ST_DATA;
          end else begin
            cnt <= cnt + CNT_W'(1);
          end
        end
        ST_DATA: begin
          if (tick) begin
            cnt     <= '0;
            sh      <= {s, sh[DATA_W-1:1]};
            bit_idx <= bit_idx + IDX_W'(1);
            if (bit_idx == last_idx) state <= parity_en ? ST_PAR : ST_STOP;
          end else begin
            cnt <= cnt + CNT_W'(1);
          end
        end
        ST_PAR: begin
          if (tick) begin
            cnt     <= '0;
            par_bit <= s;
            state   <= ST_STOP;
          end else begin
            cnt <= cnt + CNT_W'(1);
          end
        end
        ST_STOP: begin
          if (tick) begin
            cnt   <= '0;
            done  <= 1'b1;
            dout  <= word;
            fe    <= !s;
            pe    <= parity_en & ((^word) ^ par_bit ^ parity_odd);
            state <= two_stop ? ST_STOP2 : ST_IDLE;
          end else begin
            cnt <= cnt + CNT_W'(1);
          end
        end
        ST_STOP2: begin
          if (tick) begin
            cnt   <= '0;
            state <= ST_IDLE;
          end else begin
            cnt <= cnt + CNT_W'(1);
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n || mrst)
    (state != ST_IDLE) |-> (cnt < period)) else $error("counter past bit period"); // R1

  AST_GLITCH_DROP: assert property (@(posedge clk) disable iff (!rst_n || mrst)
    (state == ST_START && cnt == half - CNT_W'(1) && s) |=> (state == ST_IDLE)) else $error("glitch accepted"); // R8
endmodule

// File: rtl/async_rx_hold.sv
module async_rx_hold #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mrst,
  input  logic              done,
  input  logic [DATA_W-1:0] din,
  input  logic              fe,
  input  logic              pe,
  input  logic              out_ready,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  output logic              err_frame,
  output logic              err_parity,
  output logic              err_overrun
);
  logic rd;
  assign rd = out_valid & out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n || mrst) begin
      out_valid   <= 1'b0;
      out_data    <= '0;
      err_frame   <= 1'b0;
      err_parity  <= 1'b0;
      err_overrun <= 1'b0;
    end else begin
      if (rd) begin
        out_valid   <= 1'b0;
        err_frame   <= 1'b0;
        err_parity  <= 1'b0;
        err_overrun <= 1'b0;
      end
      if (done) begin
        if (out_valid && !rd) begin
          err_overrun <= 1'b1;
        end else begin
          out_valid  <= 1'b1;
          out_data   <= din;
          err_frame  <= fe;
          err_parity <= pe;
        end
      end
    end
  end

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && !mrst) |=> (out_valid && $stable(out_data) && $stable(err_frame) && $stable(err_parity))) else $error("held data moved"); // R4

  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && !done && !mrst) |=> !out_valid) else $error("read did not empty"); // R3

  AST_OVERRUN_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (done && out_valid && !out_ready && !mrst) |=> err_overrun) else $error("overrun missed"); // R7

  AST_MRST_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    mrst |=> (!out_valid && !err_overrun && !err_frame && !err_parity)) else $error("master reset left state"); // R1
endmodule

// File: rtl/async_rx.sv
module async_rx
  import async_rx_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int DIV_MID     = 16,
  parameter int DIV_HI      = 64,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_line,
  input  logic [1:0]        div_sel,
  input  logic              len8,
  input  logic              parity_en,
  input  logic              parity_odd,
  input  logic              two_stop,
  input  logic              out_ready,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  output logic              err_frame,
  output logic              err_parity,
  output logic              err_overrun
);
  logic              line_s;
  logic              f_done;
  logic [DATA_W-1:0] f_data;
  logic              f_fe;
  logic              f_pe;
  logic              mrst;

  assign mrst = (div_sel == DIV_MRST);

  async_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (rx_line),
    .dout (line_s)
  );

  async_rx_frame #(.DATA_W(DATA_W), .DIV_MID(DIV_MID), .DIV_HI(DIV_HI)) u_frame (
    .clk       (clk),
    .rst_n     (rst_n),
    .s         (line_s),
    .div_sel   (div_sel),
    .len8      (len8),
    .parity_en (parity_en),
    .parity_odd(parity_odd),
    .two_stop  (two_stop),
    .done      (f_done),
    .dout      (f_data),
    .fe        (f_fe),
    .pe        (f_pe)
  );

  async_rx_hold #(.DATA_W(DATA_W)) u_hold (
    .clk        (clk),
    .rst_n      (rst_n),
    .mrst       (mrst),
    .done       (f_done),
    .din        (f_data),
    .fe         (f_fe),
    .pe         (f_pe),
    .out_ready  (out_ready),
    .out_valid  (out_valid),
    .out_data   (out_data),
    .err_frame  (err_frame),
    .err_parity (err_parity),
    .err_overrun(err_overrun)
  );

  AST_SHORT_TOP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (f_done && !len8) |-> !f_data[DATA_W-1]) else $error("7-bit top bit set"); // R2
endmodule

// File: tb/async_rx_bench.sv
module async_rx_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx_line = 1'b1;
  logic [1:0] div_sel = 2'b01;
  logic       len8 = 1'b1;
  logic       parity_en = 1'b0;
  logic       parity_odd = 1'b0;
  logic       two_stop = 1'b0;
  logic       out_ready = 1'b0;
  logic       out_valid;
  logic [7:0] out_data;
  logic       err_frame;
  logic       err_parity;
  logic       err_overrun;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  async_rx u_async_rx (
    .clk(clk), .rst_n(rst_n), .rx_line(rx_line), .div_sel(div_sel),
    .len8(len8), .parity_en(parity_en), .parity_odd(parity_odd),
    .two_stop(two_stop), .out_ready(out_ready), .out_valid(out_valid),
    .out_data(out_data), .err_frame(err_frame), .err_parity(err_parity),
    .err_overrun(err_overrun)
  );

  function automatic int clocks_per_bit(logic [1:0] code);
    case (code)
      2'b01:   return 16;
      2'b10:   return 64;
      default: return 1;
    endcase
  endfunction

  function automatic logic [7:0] expect_data(logic [7:0] d, logic l8);
    return l8 ? d : {1'b0, d[6:0]};
  endfunction

  function automatic logic good_parity(logic [7:0] d, logic l8, logic odd);
    return (^expect_data(d, l8)) ^ odd;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic drive_bit(logic b, int n);
    rx_line = b;
    repeat (n) @(negedge clk);
  endtask

  task automatic send(logic [7:0] d, logic bad_stop, logic bad_par, logic low_stop2);
    int n;
    int nb;
    logic pb;
    n  = clocks_per_bit(div_sel);
    nb = len8 ? 8 : 7;
    pb = good_parity(d, len8, parity_odd) ^ bad_par;
    drive_bit(1'b0, n);
    for (int i = 0; i < nb; i++) drive_bit(d[i], n);
    if (parity_en) drive_bit(pb, n);
    drive_bit(!bad_stop, n);
    if (two_stop) drive_bit(!low_stop2, n);
    drive_bit(1'b1, n + 8);
  endtask

  task automatic do_read();
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
  endtask

  task automatic set_fmt(logic [1:0] dv, logic l8, logic pen, logic podd, logic ts);
    div_sel = dv; len8 = l8; parity_en = pen; parity_odd = podd; two_stop = ts;
    repeat (4) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin : main
    void'($urandom(32'd2024));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R3 reset valid", out_valid, 0);
    check("R3 reset flags", {err_frame, err_parity, err_overrun}, 0);

    // R1/R2: divide-by-1, 8 bits
    set_fmt(2'b00, 1, 0, 0, 0);
    send(8'hA5, 0, 0, 0);
    check("R1 x1 valid", out_valid, 1);
    check("R2 x1 data", out_data, 8'hA5);
    do_read();
    check("R3 read clears", out_valid, 0);

    // R2/R6: divide-by-16, 7 bits even parity, top bit dropped
    set_fmt(2'b01, 0, 1, 0, 0);
    send(8'hFF, 0, 0, 0);
    check("R2 7-bit data", out_data, 8'h7F);
    check("R6 even ok", err_parity, 0);
    do_read();

    // R6: divide-by-64, odd parity, corrupted
    set_fmt(2'b10, 1, 1, 1, 0);
    send(8'h3C, 0, 1, 0);
    check("R1 x64 data", out_data, 8'h3C);
    check("R6 odd bad", err_parity, 1);
    do_read();
    check("R3 flags cleared", {err_parity, err_frame}, 0);

    // R5: framing error
    set_fmt(2'b01, 1, 0, 0, 0);
    send(8'h81, 1, 0, 0);
    check("R5 frame err", err_frame, 1);
    check("R5 data", out_data, 8'h81);
    do_read();

    // R8: short lows ignored
    drive_bit(1'b0, 3);
    drive_bit(1'b1, 300);
    check("R8 x16 glitch", out_valid, 0);
    set_fmt(2'b10, 1, 0, 0, 0);
    drive_bit(1'b0, 20);
    drive_bit(1'b1, 1000);
    check("R8 x64 glitch", out_valid, 0);
    send(8'h5A, 0, 0, 0);
    check("R8 after glitch", out_data, 8'h5A);
    do_read();

    // R9: second stop bit low is not checked
    set_fmt(2'b01, 1, 0, 0, 1);
    send(8'hC3, 0, 0, 1);
    check("R9 data", out_data, 8'hC3);
    check("R9 no frame err", err_frame, 0);
    do_read();
    repeat (40) @(negedge clk);
    check("R9 no restart", out_valid, 0);

    // R4/R7: overrun under back-pressure
    set_fmt(2'b01, 1, 0, 0, 0);
    send(8'h11, 0, 0, 0);
    send(8'h22, 0, 0, 0);
    check("R7 overrun", err_overrun, 1);
    check("R4 kept first", out_data, 8'h11);
    check("R4 still valid", out_valid, 1);
    do_read();
    check("R7 cleared", {out_valid, err_overrun}, 0);

    // R1: master reset code
    send(8'h77, 1, 0, 0);
    check("R1 before mrst", out_valid, 1);
    div_sel = 2'b11;
    repeat (2) @(negedge clk);
    check("R1 mrst clears", {out_valid, err_frame, err_overrun}, 0);
    set_fmt(2'b00, 1, 0, 0, 0);
    send(8'h0F, 0, 0, 0);
    check("R1 after mrst", out_data, 8'h0F);
    do_read();

    // random frames
    for (int k = 0; k < 40; k++) begin
      logic [7:0] d;
      logic bs;
      logic bp;
      logic [1:0] dv;
      dv = 2'($urandom % 3);
      set_fmt(dv, 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));
      d  = 8'($urandom);
      bs = ($urandom % 6) == 0;
      bp = parity_en && (($urandom % 4) == 0);
      send(d, bs, bp, 0);
      check("R3 rnd valid", out_valid, 1);
      check("R2 rnd data", out_data, expect_data(d, len8));
      check("R5 rnd frame", err_frame, bs);
      check("R6 rnd parity", err_parity, bp);
      check("R7 rnd no ovr", err_overrun, 0);
      do_read();
    end

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule